// File: doc/BRIEF.md
# Crosspoint switch control memory

This block is the control store behind a 12-row by 8-column crosspoint matrix. It keeps one on/off bit for each of the 96 crosspoints and presents all of them at once as a switch-state vector. A host selects one crosspoint with a 4-bit row code and a 3-bit column code, puts the desired state on a single data bit and raises a strobe. While the strobe stays high the selected bit follows the data bit. When the strobe falls, the bit keeps the last value it saw. Every other bit is left as it was.

The row code space is sparse. Codes 0 to 5 reach rows 0 to 5, codes 8 to 13 reach rows 6 to 11, and codes 6, 7, 14 and 15 reach no row at all. A master clear input turns every switch off at once, without waiting for a clock, and overrides the strobe for as long as it is held. Level-sensitive latches are replaced here by a clocked model. Strobe, data and address pass together through a short synchroniser, so a write reaches the vector a fixed number of clocks after the inputs change. The master clear acts directly on the storage.

Top module: `xpt_ctrl_store`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears all 96 bits of `sw_state` to 0 at that edge.
- R2: With `wr_strobe` high and a valid address, `sw_state` shows the written value 3 rising clock edges after the inputs were applied.
- R3: A write changes at most one bit of `sw_state`. All other bits keep their previous values.
- R4: Row codes 6, 7, 14 and 15 select no cell. A strobe with one of these codes leaves all of `sw_state` unchanged, whatever the column and data.
- R5: While `wr_strobe` stays high, the addressed bit follows `wr_data`. Toggling the data toggles the bit, with the latency of R2.
- R6: The bit holds the value of `wr_data` that was present when `wr_strobe` fell. Data changes after the strobe is low have no effect.
- R7: A high `clr_all` forces all of `sw_state` to 0 at once, without a clock edge. While it is high, no strobe can set any bit.
- R8: Bit index = column × 12 + row. The column is `col_addr` read as binary 0–7. The row equals `row_addr` for codes 0–5 and `row_addr` − 2 for codes 8–13.
- R9: A 1 in a bit means the crosspoint is on. Writing 0 to a bit that holds 1 turns that crosspoint off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock of the clocked latch model |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| clr_all | input | 1 | Asynchronous active-high master clear, turns every switch off |
| row_addr | input | 4 | Sparse row code, codes 6, 7, 14, 15 unmapped |
| col_addr | input | 3 | Binary column number |
| wr_data | input | 1 | State to write, 1 = on |
| wr_strobe | input | 1 | Active-high write enable, the cell is transparent while high |
| sw_state | output | 96 | One bit per crosspoint, index column × 12 + row |

## Verification
The master clear and a strobe write can act in the same cycle. The bench raises `clr_all` between clock edges while a strobe with data 1 is held on a valid address. It expects the vector to read all zero before the next edge and on every edge for as long as the clear is held. It then releases the clear with the strobe low and expects no bit to reappear. Strobe fall and data change also coincide: the bench drops the strobe and flips the data on the same edge and expects the earlier value to stay.

// File: rtl/xpt_pkg.sv
// Shared geometry and the request record of the crosspoint control store.
// Assumes an even row count split into two banks of equal size. The top
// bit of the row code picks the bank and the low bits pick a row inside it.
package xpt_pkg;
    localparam int unsigned ROWS      = 12;
    localparam int unsigned COLS      = 8;
    localparam int unsigned ROW_AW    = 4;
    localparam int unsigned COL_AW    = 3;
    localparam int unsigned CELLS     = ROWS * COLS;
    localparam int unsigned BANK_ROWS = ROWS / 2;
    localparam int unsigned LOW_W     = ROW_AW - 1;

    // One sampled host request, carried through the synchroniser as a unit.
    typedef struct packed {
        logic              stb;
        logic              dat;
        logic [ROW_AW-1:0] row;
        logic [COL_AW-1:0] col;
    } xpt_req_t;
endpackage

// File: rtl/xpt_in_sync.sv
// Input synchroniser: a chain of STAGES flip-flop ranks that carries
// strobe, data and address together, so the address is always seen with
// the strobe it came with. Assumes the host holds the address across each
// strobe pulse. The master clear empties every rank at once.
module xpt_in_sync
    import xpt_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_all,
    input  xpt_req_t req_in,
    output xpt_req_t req_out
);
    xpt_req_t stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First rank: capture the raw port values.
            always_ff @(posedge clk or posedge clr_all) begin
                if (clr_all)     stage_q[s] <= '0;
                else if (!rst_n) stage_q[s] <= '0;
                else             stage_q[s] <= req_in;
            end
        end else begin : g_next
            // Later ranks: shift the request one rank along.
            always_ff @(posedge clk or posedge clr_all) begin
                if (clr_all)     stage_q[s] <= '0;
                else if (!rst_n) stage_q[s] <= '0;
                else             stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign req_out = stage_q[STAGES-1];
endmodule

// File: rtl/xpt_addr_dec.sv
// Address decoder: turns the sparse row code and the binary column code
// into one write enable per cell, gated by the synchronised strobe. Row
// codes whose low bits reach past the bank size enable nothing.
// Assumes BANK_ROWS <= 2**LOW_W.
module xpt_addr_dec
    import xpt_pkg::*;
(
    input  logic [ROW_AW-1:0] row_code,
    input  logic [COL_AW-1:0] col_code,
    input  logic              strobe,
    output logic [CELLS-1:0]  cell_en
);
    logic             bank;
    logic [LOW_W-1:0] low;
    logic [ROWS-1:0]  row_oh;
    logic [COLS-1:0]  col_oh;

    assign bank = row_code[ROW_AW-1];
    assign low  = row_code[LOW_W-1:0];

    // Row one-hot: lower bank for a clear top bit, upper bank otherwise.
    always_comb begin
        row_oh = '0;
        for (int r = 0; r < BANK_ROWS; r++) begin
            row_oh[r]             = !bank && (low == LOW_W'(r));
            row_oh[r + BANK_ROWS] =  bank && (low == LOW_W'(r));
        end
    end

    // Column one-hot from the binary column number.
    always_comb begin
        col_oh = '0;
        for (int c = 0; c < COLS; c++) begin
            col_oh[c] = (col_code == COL_AW'(c));
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            // Cell enable: strobe AND row select AND column select.
            assign cell_en[c*ROWS + r] = strobe & col_oh[c] & row_oh[r];
        end
    end
endmodule

// File: rtl/xpt_cell_array.sv
// Cell array: one storage bit per crosspoint. A cell loads the shared
// write bit on every clock its enable is high, which models a transparent
// latch sampled by the clock. The master clear empties all cells without
// a clock edge. The synchronous reset empties them on an edge.
module xpt_cell_array
    import xpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [CELLS-1:0] cell_en,
    input  logic             wr_bit,
    output logic [CELLS-1:0] cell_q
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        // One cell: clear has priority, then reset, then an enabled load.
        always_ff @(posedge clk or posedge clr_all) begin
            if (clr_all)         cell_q[i] <= 1'b0;
            else if (!rst_n)     cell_q[i] <= 1'b0;
            else if (cell_en[i]) cell_q[i] <= wr_bit;
        end
    end
endmodule

// File: rtl/xpt_ctrl_store.sv
// Crosspoint control store, top level. Samples the host request through
// the synchroniser, decodes it to a single cell enable and updates the
// cell array. A write appears on sw_state SYNC_STAGES + 1 edges after the
// inputs. Assumes the address is held from strobe rise until SYNC_STAGES
// clocks after strobe fall, and each strobe level lasts at least
// SYNC_STAGES + 1 clocks.
module xpt_ctrl_store
    import xpt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [ROW_AW-1:0] row_addr,
    input  logic [COL_AW-1:0] col_addr,
    input  logic              wr_data,
    input  logic              wr_strobe,
    output logic [CELLS-1:0]  sw_state
);
    xpt_req_t         raw_req;
    xpt_req_t         sync_req;
    logic [CELLS-1:0] cell_en;

    // Bundle the port values into one request record.
    always_comb begin
        raw_req.stb = wr_strobe;
        raw_req.dat = wr_data;
        raw_req.row = row_addr;
        raw_req.col = col_addr;
    end

    xpt_in_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .req_in  (raw_req),
        .req_out (sync_req)
    );

    xpt_addr_dec i_dec (
        .row_code (sync_req.row),
        .col_code (sync_req.col),
        .strobe   (sync_req.stb),
        .cell_en  (cell_en)
    );

    xpt_cell_array i_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .cell_en (cell_en),
        .wr_bit  (sync_req.dat),
        .cell_q  (sw_state)
    );
endmodule

// File: rtl/xpt_ctrl_store_chk.sv
// Property checker for the crosspoint control store. It watches the
// synchronised request and the switch vector, and works out the target
// cell on its own from the sparse row mapping.
module xpt_ctrl_store_chk
    import xpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clr_all,
    input logic              sync_stb,
    input logic              sync_dat,
    input logic [ROW_AW-1:0] sync_row,
    input logic [COL_AW-1:0] sync_col,
    input logic [CELLS-1:0]  sw_state
);
    logic row_ok;
    int   exp_idx;

    // Target cell from the mapping: bank offset plus the in-bank row.
    always_comb begin
        row_ok  = (int'(sync_row[LOW_W-1:0]) < BANK_ROWS);
        exp_idx = int'(sync_col) * ROWS
                + (sync_row[ROW_AW-1] ? BANK_ROWS : 0)
                + int'(sync_row[LOW_W-1:0]);
    end

    p_rst_clear_r1: assert property (@(posedge clk) disable iff (clr_all)
        !rst_n |=> (sw_state == '0));

    p_follow_data_r5: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        (sync_stb && row_ok) |=> (sw_state[$past(exp_idx)] == $past(sync_dat)));

    p_single_cell_r3: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        ($past(rst_n) && !$past(clr_all)) |-> ($countones(sw_state ^ $past(sw_state)) <= 1));

    p_unmapped_row_r4: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        (sync_stb && !row_ok) |=> $stable(sw_state));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        !sync_stb |=> $stable(sw_state));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |-> (sw_state == '0));
endmodule

bind xpt_ctrl_store xpt_ctrl_store_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .sync_stb (sync_req.stb),
    .sync_dat (sync_req.dat),
    .sync_row (sync_req.row),
    .sync_col (sync_req.col),
    .sw_state (sw_state)
);

// File: tb/test_xpt_ctrl_store.sv
// Bench for the crosspoint control store: a behavioural model with a
// two-entry request queue is compared with the outputs on every falling
// clock edge, and directed checks cover each requirement.
module test_xpt_ctrl_store;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_all = 1'b0;
    logic [3:0]  row_addr = '0;
    logic [2:0]  col_addr = '0;
    logic        wr_data = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [95:0] sw_state;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";

    typedef struct {
        bit stb;
        bit dat;
        int row;
        int col;
    } smp_t;

    smp_t        pipe[$];
    logic [95:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpt_ctrl_store i_xpt_ctrl_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .wr_data   (wr_data),
        .wr_strobe (wr_strobe),
        .sw_state  (sw_state)
    );

    function automatic bit code_valid(int code);
        return (code < 6) || (code >= 8 && code < 14);
    endfunction

    function automatic int cell_of(int code, int col);
        return col * 12 + ((code < 6) ? code : code - 2);
    endfunction

    function automatic smp_t idle_smp();
        smp_t z;
        z.stb = 1'b0; z.dat = 1'b0; z.row = 0; z.col = 0;
        return z;
    endfunction

    initial begin
        pipe.push_back(idle_smp());
        pipe.push_back(idle_smp());
    end

    // Reference model: requests take two clocks, then land on one cell.
    always @(posedge clk) begin : p_model
        smp_t e;
        smp_t n;
        if (clr_all || !rst_n) begin
            model = '0;
            pipe.delete();
            pipe.push_back(idle_smp());
            pipe.push_back(idle_smp());
        end else begin
            e = pipe.pop_front();
            if (e.stb && code_valid(e.row))
                model[cell_of(e.row, e.col)] = e.dat;
            n.stb = wr_strobe; n.dat = wr_data;
            n.row = int'(row_addr); n.col = int'(col_addr);
            pipe.push_back(n);
        end
    end

    // Master clear acts on the model at once, like on the storage.
    always @(posedge clr_all) model = '0;

    // Per-clock comparison with the model.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (sw_state !== model) begin
                errors++;
                $display("FAIL %s model compare: actual=%h expected=%h", phase, sw_state, model);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=60000", cycles);
            finish_run();
        end
    end

    task automatic check_vec(string req, logic [95:0] exp);
        checks++;
        if (sw_state !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, sw_state, exp);
        end
    endtask

    task automatic check_bit(string req, int idx, bit exp);
        checks++;
        if (sw_state[idx] !== exp) begin
            errors++;
            $display("FAIL %s: bit %0d actual=%b expected=%b", req, idx, sw_state[idx], exp);
        end
    endtask

    // One full strobe pulse of three clocks, address held three more.
    task automatic do_write(int code, int col, bit d);
        @(negedge clk);
        row_addr = 4'(code); col_addr = 3'(col); wr_data = d; wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : p_main
        logic [95:0] pat;
        logic [15:0] lfsr;
        int          idx;

        // R1: reset state.
        phase = "R1";
        repeat (3) @(negedge clk);
        check_vec("R1 reset clears", '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R8, R9: every valid address, set then clear, alone.
        for (int col = 0; col < 8; col++) begin
            for (int code = 0; code < 16; code++) begin
                if (code_valid(code)) begin
                    phase = "R8";
                    do_write(code, col, 1'b1);
                    check_vec("R8 R2 mapping of single set", 96'b1 << cell_of(code, col));
                    phase = "R9";
                    do_write(code, col, 1'b0);
                    check_vec("R9 write zero turns off", '0);
                end
            end
        end

        // R2 latency: the bit is still 0 after two edges, 1 after three.
        phase = "R2";
        @(negedge clk);
        row_addr = 4'd2; col_addr = 3'd1; wr_data = 1'b1; wr_strobe = 1'b1;
        repeat (2) @(negedge clk);
        check_bit("R2 not yet after two edges", cell_of(2, 1), 1'b0);
        @(negedge clk);
        check_bit("R2 visible after three edges", cell_of(2, 1), 1'b1);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);

        // R4: unmapped row codes change nothing.
        phase = "R4";
        do_write(5, 3, 1'b1);
        do_write(8, 3, 1'b1);
        do_write(13, 7, 1'b1);
        do_write(0, 0, 1'b1);
        pat = '0;
        pat[cell_of(2, 1)]  = 1'b1;
        pat[cell_of(5, 3)]  = 1'b1;
        pat[cell_of(8, 3)]  = 1'b1;
        pat[cell_of(13, 7)] = 1'b1;
        pat[cell_of(0, 0)]  = 1'b1;
        check_vec("R4 prefill", pat);
        foreach (pat[k]) begin end
        for (int col = 0; col < 8; col++) begin
            do_write(6, col, 1'b1);
            do_write(7, col, 1'b0);
            do_write(14, col, 1'b1);
            do_write(15, col, 1'b0);
            check_vec("R4 unmapped codes ignored", pat);
        end

        // R5: transparent while strobe high.
        phase = "R5";
        idx = cell_of(9, 4);
        @(negedge clk);
        row_addr = 4'd9; col_addr = 3'd4; wr_data = 1'b1; wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R5 follows data high", idx, 1'b1);
        wr_data = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R5 follows data low", idx, 1'b0);
        wr_data = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R5 follows data high again", idx, 1'b1);

        // R6: strobe fall and data flip on the same edge keep the old value.
        phase = "R6";
        wr_strobe = 1'b0; wr_data = 1'b0;
        repeat (4) @(negedge clk);
        check_bit("R6 value at strobe fall held", idx, 1'b1);
        wr_data = 1'b1;
        repeat (4) @(negedge clk);
        check_bit("R6 data after fall ignored", idx, 1'b1);

        // R7: clear raised between edges while a write of 1 is pending.
        phase = "R7";
        @(negedge clk);
        row_addr = 4'd11; col_addr = 3'd6; wr_data = 1'b1; wr_strobe = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        clr_all = 1'b1;
        #1;
        check_vec("R7 clear without clock", '0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check_vec("R7 clear beats strobe", '0);
        end
        wr_strobe = 1'b0;
        clr_all = 1'b0;
        repeat (5) @(negedge clk);
        check_vec("R7 nothing returns after clear", '0);

        // R3: pseudo-random writes, any code, compared with the model.
        phase = "R3";
        lfsr = 16'hACE1;
        for (int k = 0; k < 120; k++) begin
            do_write(int'(lfsr[3:0]), int'(lfsr[6:4]), lfsr[7]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        check_vec("R3 random writes match model", model);

        // R1: synchronous reset from a non-empty state.
        phase = "R1";
        do_write(1, 2, 1'b1);
        check_bit("R1 setup bit", cell_of(1, 2), 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_vec("R1 reset clears stored bits", '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule